// File: doc/BRIEF.md
# Selectable-Length Moving Average Filter

This block smooths a stream of signed samples, nominally one every 10 ms, by averaging the most recent samples over a window whose length is chosen at run time. A three-bit length code picks the window: a pass-through setting, or a window of 5, 8, 12, 20 or 36 samples. Each accepted sample produces exactly one averaged result, which appears after a fixed pipeline delay with its own valid strobe.

A running sum is kept with a circular sample store. The newest sample is added and the sample leaving the window is subtracted. Changing the length code empties the window. While the window is refilling, each result is the mean of the samples received since the flush. Division by the current sample count uses a precomputed fixed-point reciprocal. Rounding is applied to the magnitude, so results are rounded to the nearest integer with halves going away from zero.

Top module: `mavg_filter`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `avg_vld` is 0 and `avg_data` is 0.
- R2: For every cycle in which `smp_vld` is high, `avg_vld` is high for exactly one cycle, four clock cycles later. `avg_vld` is never high otherwise.
- R3: With `len_sel` = 0, `avg_data` equals the input sample bit for bit.
- R4: `len_sel` codes 1, 2, 3, 4 and 5 select windows of 5, 8, 12, 20 and 36 samples.
- R5: Once the window holds N samples, each result is the rounded mean of the N most recent samples. This holds over the full 16-bit signed range.
- R6: While fewer than N samples have arrived since the last flush, each result is the rounded mean of all samples received since that flush.
- R7: Means are rounded to the nearest integer. An exact half rounds away from zero, so +0.5 gives 1 and -0.5 gives -1.
- R8: Any change of `len_sel` empties the window. A sample accepted in the same cycle as the change is the first sample of the new window.
- R9: Codes 6 and 7 behave like code 0 (pass-through).
- R10: Samples may arrive on consecutive clock cycles. Every one of them is averaged correctly.
- R11: While `avg_vld` is low, `avg_data` keeps the last result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| len_sel | input | 3 | Window length code (0 = pass-through) |
| smp_vld | input | 1 | Input sample strobe |
| smp_data | input | 16 | Signed input sample |
| avg_vld | output | 1 | Result strobe |
| avg_data | output | 16 | Signed averaged result |

## Verification
Every result is due on the fourth rising edge after the edge that captured its sample, counting the capturing edge as the first. A length change affects the sample taken on the same edge. The bench keeps a behavioural window, which is a queue that is emptied on each code change, and computes the rounded mean with integer arithmetic. It delays the expected strobe and value through a four-stage shift register clocked on the same edges as the design. Both `avg_vld` and `avg_data` are compared against that delayed expectation at every falling edge, so an early result, a late result or a value change between results is each reported against its requirement.

// File: rtl/mavg_pkg.sv
package mavg_pkg;

  localparam int unsigned SEL_W   = 3;
  localparam int unsigned MAX_WIN = 36;

  typedef logic [SEL_W-1:0] len_code_t;

  // Window length for a code; unknown codes fall back to one sample.
  function automatic int unsigned win_len(len_code_t code);
    case (code)
      3'd1:    return 5;
      3'd2:    return 8;
      3'd3:    return 12;
      3'd4:    return 20;
      3'd5:    return 36;
      default: return 1;
    endcase
  endfunction

  // ceil(2^frac / d): error is positive, so magnitude ties round up.
  function automatic longint unsigned recip_ceil(int unsigned d, int unsigned frac);
    longint unsigned one;
    if (d == 0) return 64'd0;
    one = 64'd1 << frac;
    return (one + 64'(d) - 64'd1) / 64'(d);
  endfunction

endpackage

// File: rtl/mavg_ring.sv
module mavg_ring #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DEPTH  = 36,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  // Read-first single port: the old entry comes out as the new one goes in.
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end

endmodule

// File: rtl/mavg_window.sv
module mavg_window
  import mavg_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DEPTH  = 36,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned ACC_W = DATA_W + $clog2(DEPTH)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  len_code_t                len_sel,
  input  logic                     smp_vld,
  input  logic signed [DATA_W-1:0] smp_data,
  output logic                     sum_vld,
  output logic signed [ACC_W-1:0]  sum,
  output logic [CNT_W-1:0]         sum_div
);

  len_code_t          sel_q;
  logic               chg;
  logic [CNT_W-1:0]   n_len, cnt, cnt_cur;
  logic [AW-1:0]      ptr, ptr_cur;
  logic [DATA_W-1:0]  old_q;

  logic                     s1_vld, s1_first, s1_full;
  logic signed [DATA_W-1:0] s1_data;
  logic [CNT_W-1:0]         s1_div;

  assign chg     = (len_sel != sel_q);
  assign n_len   = CNT_W'(win_len(len_sel));
  assign cnt_cur = chg ? '0 : cnt;
  assign ptr_cur = chg ? '0 : ptr;

  mavg_ring #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ring (
    .clk   (clk),
    .we    (smp_vld),
    .addr  (ptr_cur),
    .wdata (smp_data),
    .rdata (old_q)
  );

  // Stage 0: window bookkeeping and capture of the sample.
  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q    <= '0;
      cnt      <= '0;
      ptr      <= '0;
      s1_vld   <= 1'b0;
      s1_first <= 1'b0;
      s1_full  <= 1'b0;
      s1_data  <= '0;
      s1_div   <= '0;
    end else begin
      sel_q  <= len_sel;
      s1_vld <= smp_vld;
      if (smp_vld) begin
        ptr      <= (ptr_cur == AW'(n_len - 1'b1)) ? '0 : ptr_cur + 1'b1;
        cnt      <= (cnt_cur == n_len) ? n_len : cnt_cur + 1'b1;
        s1_data  <= smp_data;
        s1_first <= (cnt_cur == '0);
        s1_full  <= (cnt_cur == n_len);
        s1_div   <= (cnt_cur == n_len) ? n_len : cnt_cur + 1'b1;
      end else if (chg) begin
        ptr <= '0;
        cnt <= '0;
      end
    end
  end

  logic signed [ACC_W-1:0] new_x, old_x;
  assign new_x = ACC_W'(s1_data);
  assign old_x = s1_full ? ACC_W'($signed(old_q)) : '0;

  // Stage 1: running sum.
  always_ff @(posedge clk) begin
    if (rst) begin
      sum_vld <= 1'b0;
      sum     <= '0;
      sum_div <= '0;
    end else begin
      sum_vld <= s1_vld;
      if (s1_vld) begin
        sum     <= s1_first ? new_x : sum + new_x - old_x;
        sum_div <= s1_div;
      end
    end
  end

  AST_CNT_BOUND:  assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(win_len(sel_q)));                                  // R6
  AST_PTR_BOUND:  assert property (@(posedge clk) disable iff (rst)
    ptr < AW'(win_len(sel_q)));                                      // R5
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (chg && !smp_vld) |=> (cnt == '0));                              // R8
  AST_FLUSH_FIRST: assert property (@(posedge clk) disable iff (rst)
    (chg && smp_vld) |=> (cnt == CNT_W'(1)));                        // R8
  AST_DIV_RANGE:  assert property (@(posedge clk) disable iff (rst)
    sum_vld |-> (sum_div != '0 && sum_div <= CNT_W'(DEPTH)));        // R6

endmodule

// File: rtl/mavg_scale.sv
module mavg_scale
  import mavg_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DEPTH  = 36,
  parameter int unsigned FRAC_W = 30,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned ACC_W = DATA_W + $clog2(DEPTH),
  localparam int unsigned RW    = FRAC_W + 1,
  localparam int unsigned PW    = ACC_W + RW
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_vld,
  input  logic signed [ACC_W-1:0]  in_sum,
  input  logic [CNT_W-1:0]         in_div,
  output logic                     out_vld,
  output logic signed [DATA_W-1:0] out_data
);

  localparam logic [PW-1:0] HALF = PW'(1) << (FRAC_W - 1);

  logic [RW-1:0] rtab [DEPTH+1];

  for (genvar g = 0; g <= DEPTH; g++) begin : g_rtab
    assign rtab[g] = RW'(recip_ceil(g, FRAC_W));
  end

  logic [ACC_W-1:0] abs_sum;
  assign abs_sum = in_sum[ACC_W-1] ? $unsigned(-in_sum) : $unsigned(in_sum);

  logic          p_vld, p_neg;
  logic [PW-1:0] prod;

  // Stage 2: magnitude times reciprocal.
  always_ff @(posedge clk) begin
    if (rst) begin
      p_vld <= 1'b0;
      p_neg <= 1'b0;
      prod  <= '0;
    end else begin
      p_vld <= in_vld;
      if (in_vld) begin
        p_neg <= in_sum[ACC_W-1];
        prod  <= PW'(abs_sum) * PW'(rtab[in_div]);
      end
    end
  end

  logic [PW-1:0]   rnd;
  logic [DATA_W:0] mag_r;
  assign rnd   = prod + HALF;
  assign mag_r = rnd[FRAC_W +: DATA_W+1];

  // Stage 3: round, restore sign, register output.
  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld  <= 1'b0;
      out_data <= '0;
    end else begin
      out_vld <= p_vld;
      if (p_vld) out_data <= p_neg ? DATA_W'(-mag_r) : DATA_W'(mag_r);
    end
  end

  AST_MAG_RANGE: assert property (@(posedge clk) disable iff (rst)
    p_vld |-> (rnd[PW-1:FRAC_W+DATA_W+1] == '0 &&
               mag_r <= (DATA_W+1)'(p_neg ? (1 << (DATA_W-1)) : (1 << (DATA_W-1)) - 1))); // R5
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !out_vld |-> $stable(out_data));                                 // R11

endmodule

// File: rtl/mavg_filter.sv
module mavg_filter
  import mavg_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DEPTH  = MAX_WIN,
  parameter int unsigned FRAC_W = 30,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned ACC_W = DATA_W + $clog2(DEPTH)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [2:0]               len_sel,
  input  logic                     smp_vld,
  input  logic signed [DATA_W-1:0] smp_data,
  output logic                     avg_vld,
  output logic signed [DATA_W-1:0] avg_data
);

  logic                    sum_vld;
  logic signed [ACC_W-1:0] sum;
  logic [CNT_W-1:0]        sum_div;

  mavg_window #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_window (
    .clk      (clk),
    .rst      (rst),
    .len_sel  (len_code_t'(len_sel)),
    .smp_vld  (smp_vld),
    .smp_data (smp_data),
    .sum_vld  (sum_vld),
    .sum      (sum),
    .sum_div  (sum_div)
  );

  mavg_scale #(.DATA_W(DATA_W), .DEPTH(DEPTH), .FRAC_W(FRAC_W)) u_scale (
    .clk      (clk),
    .rst      (rst),
    .in_vld   (sum_vld),
    .in_sum   (sum),
    .in_div   (sum_div),
    .out_vld  (avg_vld),
    .out_data (avg_data)
  );

  // Cycles since reset, saturating; lets the latency check look back safely.
  logic [2:0] age;
  always_ff @(posedge clk) begin
    if (rst)              age <= '0;
    else if (age != 3'd4) age <= age + 1'b1;
  end

  AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (age == 3'd4) |-> (avg_vld == $past(smp_vld, 4)));               // R2
  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (!avg_vld && avg_data == '0));                    // R1

endmodule

// File: tb/sim_mavg_filter.sv
module sim_mavg_filter;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [2:0]        len_sel = 3'd0;
  logic              smp_vld = 1'b0;
  logic signed [15:0] smp_data = '0;
  logic              avg_vld;
  logic signed [15:0] avg_data;

  int checks = 0;
  int fails  = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mavg_filter u0 (
    .clk(clk), .rst(rst), .len_sel(len_sel), .smp_vld(smp_vld),
    .smp_data(smp_data), .avg_vld(avg_vld), .avg_data(avg_data)
  );

  // ---------------- reference model ----------------
  int win[$];
  int prev_sel = 0;
  bit pv0, pv1, pv2, ev;
  int pd0, pd1, pd2, ed;

  function automatic int len_of(int c);
    case (c)
      1: return 5;  2: return 8;  3: return 12;
      4: return 20; 5: return 36; default: return 1;
    endcase
  endfunction

  function automatic int round_mean(longint s, int d);
    longint m = (s < 0) ? -s : s;
    longint q = (2 * m + d) / (2 * d);
    return (s < 0) ? -int'(q) : int'(q);
  endfunction

  always @(posedge clk) begin
    bit nv;
    int nd;
    longint s;
    nv = 1'b0; nd = 0;
    if (rst) begin
      win.delete();
      prev_sel = 0;
      pv0 <= 0; pv1 <= 0; pv2 <= 0; ev <= 0;
      pd0 <= 0; pd1 <= 0; pd2 <= 0; ed <= 0;
    end else begin
      if (int'(len_sel) != prev_sel) begin
        win.delete();
        prev_sel = int'(len_sel);
      end
      if (smp_vld) begin
        win.push_back(int'(smp_data));
        if (win.size() > len_of(int'(len_sel))) void'(win.pop_front());
        s = 0;
        foreach (win[i]) s += win[i];
        nv = 1'b1;
        nd = round_mean(s, win.size());
      end
      pv0 <= nv;  pd0 <= nd;
      pv1 <= pv0; pd1 <= pd0;
      pv2 <= pv1; pd2 <= pd1;
      ev  <= pv2;
      if (pv2) ed <= pd2;
    end
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (avg_vld !== ev) begin
        fails++;
        $display("FAIL R2 avg_vld act %0d exp %0d (phase %s)", avg_vld, ev, cur_req);
      end else if (int'(avg_data) != ed) begin
        fails++;
        if (ev) $display("FAIL %s avg_data act %0d exp %0d", cur_req, avg_data, ed);
        else    $display("FAIL R11 held avg_data act %0d exp %0d", avg_data, ed);
      end
    end
  end

  // ---------------- stimulus ----------------
  int lcg = 12345;
  function automatic int next_val();
    lcg = lcg * 1103515245 + 12345;
    return (lcg >>> 8) % 32768;
  endfunction

  task automatic send(int v);
    @(negedge clk);
    smp_vld  = 1'b1;
    smp_data = 16'(v);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      smp_vld = 1'b0;
    end
  endtask

  task automatic set_sel(int c);
    @(negedge clk);
    smp_vld = 1'b0;
    len_sel = 3'(c);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired in phase %s", cur_req);
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: quiet outputs during and right after reset
    checks++;
    if (avg_vld !== 1'b0 || avg_data !== 16'sd0) begin
      fails++;
      $display("FAIL R1 during reset act %0d/%0d exp 0/0", avg_vld, avg_data);
    end
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (avg_vld !== 1'b0 || avg_data !== 16'sd0) begin
      fails++;
      $display("FAIL R1 after reset act %0d/%0d exp 0/0", avg_vld, avg_data);
    end

    cur_req = "R3";  // pass-through, with gaps (also R11 hold)
    send(100); idle(2); send(-5); idle(3); send(32767); idle(1);
    send(-32768); idle(6);

    cur_req = "R6";  // fill of a 5-sample window
    set_sel(1); idle(2);
    send(10); idle(1); send(20); idle(1); send(30); send(41); idle(2);
    cur_req = "R5";
    for (int i = 0; i < 12; i++) begin send(next_val() - 16384); idle(i % 3); end
    idle(6);

    cur_req = "R7";  // halves in an 8-sample window
    set_sel(2);
    for (int i = 0; i < 4; i++) send(1);
    for (int i = 0; i < 4; i++) send(0);
    for (int i = 0; i < 8; i++) send(-1);
    send(3); send(-2); send(7); send(-6);
    idle(6);

    cur_req = "R4";  // 12, 20, 36 windows
    for (int c = 3; c <= 5; c++) begin
      set_sel(c);
      for (int i = 0; i < 45; i++) begin send(next_val() - 16384); idle(i % 3); end
      idle(5);
    end

    cur_req = "R10"; // every cycle, longest window
    for (int i = 0; i < 80; i++) send(next_val() - 16384);
    idle(6);

    cur_req = "R8";  // change in the same cycle as a sample, and alone
    for (int i = 0; i < 10; i++) send(next_val() - 16384);
    @(negedge clk); len_sel = 3'd1; smp_vld = 1'b1; smp_data = 16'sd999;
    send(1); send(2);
    set_sel(2); send(-300); send(-301); idle(1);
    set_sel(1); set_sel(2); send(77); send(78); send(80);
    idle(6);

    cur_req = "R9";  // undefined codes pass through
    set_sel(6); send(1234); send(-4321); idle(2);
    set_sel(7); send(-1); send(32767); idle(6);

    cur_req = "R5";  // full-scale windows
    set_sel(4);
    for (int i = 0; i < 25; i++) send(32767);
    for (int i = 0; i < 25; i++) send(-32768);
    set_sel(5);
    for (int i = 0; i < 40; i++) send(-32768);
    idle(8);

    finish_run();
  end

endmodule